// File: doc/BRIEF.md
# Ending-Status Collection Sequencer

This block assembles the 16-bit ending-status word once a disk-controller operation has finished. A one-cycle `start` pulse latches the 4-bit controller status. The block then talks to the controller chip through a simple register port. Every chip read has two parts: first a command word that selects the register, then a fixed settling delay, after which the chip's read data is sampled.

The sequence runs in a fixed order:
1. Read the chip status.
2. Fetch the standard result, but only when the status says one is waiting.
3. Issue the drive-status command.
4. Poll the chip status until it is no longer busy.
5. Read the drive status back from the result register.

The three sources are packed into separate bit fields of one word. That word is presented together with a one-cycle `done` pulse.

If the chip stays busy for more polls than `poll_limit` allows, the block gives up. It still reports `done`, with the drive field left at zero and `poll_timeout` set. The working word is cleared at every start, so no field survives from an earlier operation.

Top module: `end_status_seq`

## Requirements
- R1: While and after reset, `done`, `end_status`, `poll_timeout`, `chip_cmd_wr` and `chip_rd_stb` are all 0.
- R2: `end_status[3:0]` equals `ctrl_status` sampled on the accepted `start`. Every field not filled during the current operation reads 0, whatever earlier operations produced.
- R3: The first chip command of each operation is the status-read word 0x0000. The result-read word 0x1000 is issued after that first status read only when bit 4 (result full) of the returned status is 1.
- R4: When the standard result is fetched, its data bits 5:2 appear in `end_status[15:12]`; its other bits are discarded.
- R5: After the first status read, and after the optional result read, the drive-status command word 0x806C is written exactly once per operation.
- R6: After the drive-status command, the status word 0x0000 is issued again after every status read that returns bit 7 (busy) as 1. Once a read returns bit 7 as 0, the result word 0x1000 is issued, and data bits 6:0 of that read appear in `end_status[10:4]`.
- R7: Every `chip_rd_stb` comes exactly DELAY (8) cycles after the `chip_cmd_wr` that selected the register, and `chip_rd_data` is sampled in that strobe cycle.
- R8: If max(`poll_limit`,1) consecutive busy polls occur, `done` is raised with `poll_timeout`=1. In that case no drive result is read and `end_status[10:4]` is 0. A normal finish leaves `poll_timeout`=0.
- R9: `done` is a single-cycle pulse. `end_status` and `poll_timeout` change only in a `done` cycle and hold until the next one.
- R10: A `start` pulse that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a collection (single-cycle pulse) |
| ctrl_status | input | 4 | controller status, latched on start |
| poll_limit | input | 8 | allowed busy polls before giving up (0 acts as 1) |
| chip_cmd_wr | output | 1 | write strobe for the chip command register |
| chip_cmd_word | output | 16 | command word written with chip_cmd_wr |
| chip_rd_stb | output | 1 | read strobe; chip_rd_data is sampled in this cycle |
| chip_rd_data | input | 8 | chip read data |
| done | output | 1 | ending status is ready (single-cycle pulse) |
| end_status | output | 16 | packed ending-status word |
| poll_timeout | output | 1 | last operation ended on the busy-poll limit |

## Verification
A read strobe is due exactly 8 cycles after its command write. The bench times every such pair against its own cycle counter, and a checker counter checks the same spacing. `end_status` and `poll_timeout` are due in the same cycle as `done`. Because `done` is not at a fixed latency, the bench waits for it on falling edges and checks the packed word there; it checks on the next falling edge that `done` has dropped and the word has held. Command counts per operation are taken from snapshots around each run, and the bench works out the expected number of status, result and drive commands from the busy count and the limit it set up.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_RES, ST_DRV, ST_POLL, ST_DRES
  } seq_state_t;

  typedef enum logic [1:0] {
    FLD_NONE, FLD_RESULT, FLD_DRIVE
  } fld_sel_t;
endpackage

// File: rtl/esc_chip_access.sv
// Chip register access engine: a command write, then for reads a fixed
// settling delay before the data is sampled.
module esc_chip_access #(
  parameter int DW    = 8,
  parameter int CMDW  = 16,
  parameter int DELAY = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_rd,
  input  logic            go_wr,
  input  logic [CMDW-1:0] cmd_in,
  output logic            cmd_wr,
  output logic [CMDW-1:0] cmd_word,
  output logic            rd_stb,
  input  logic [DW-1:0]   rd_data,
  output logic            rdy,
  output logic [DW-1:0]   data_out
);
  localparam int CNTW = $clog2(DELAY + 1);

  logic            busy_q, is_rd_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      is_rd_q  <= 1'b0;
      cnt_q    <= '0;
      cmd_wr   <= 1'b0;
      cmd_word <= '0;
      rd_stb   <= 1'b0;
      rdy      <= 1'b0;
      data_out <= '0;
    end else begin
      cmd_wr <= 1'b0;
      rd_stb <= 1'b0;
      rdy    <= 1'b0;
      if (!busy_q) begin
        if (go_rd || go_wr) begin
          busy_q   <= 1'b1;
          is_rd_q  <= go_rd;
          cmd_wr   <= 1'b1;
          cmd_word <= cmd_in;
          cnt_q    <= '0;
        end
      end else if (!is_rd_q) begin
        busy_q <= 1'b0;
        rdy    <= 1'b1;
      end else if (rd_stb) begin
        data_out <= rd_data;
        rdy      <= 1'b1;
        busy_q   <= 1'b0;
      end else begin
        if (cnt_q == CNTW'(DELAY - 1)) rd_stb <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/esc_field_pack.sv
// Merges one chip value into the ending-status word.
module esc_field_pack
  import esc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SW        = 16,
  parameter int RES_SHIFT = 10,
  parameter int RES_LSB   = 12,
  parameter int DRV_BITS  = 7,
  parameter int DRV_SHIFT = 4
) (
  input  logic [SW-1:0] acc,
  input  logic [DW-1:0] data,
  input  fld_sel_t      sel,
  output logic [SW-1:0] merged
);
  localparam logic [SW-1:0] RES_MASK = ~((SW'(1) << RES_LSB) - SW'(1));
  localparam logic [SW-1:0] DRV_MASK = (SW'(1) << DRV_BITS) - SW'(1);

  logic [SW-1:0] wide;

  always_comb begin
    wide = SW'(data);
    unique case (sel)
      FLD_RESULT: merged = acc | ((wide << RES_SHIFT) & RES_MASK);
      FLD_DRIVE:  merged = acc | ((wide & DRV_MASK) << DRV_SHIFT);
      default:    merged = acc;
    endcase
  end
endmodule

// File: rtl/esc_poll_timer.sv
// Counts busy polls; 'last' flags that the current busy poll uses up the limit.
module esc_poll_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [LW-1:0] limit,
  output logic          last
);
  logic [LW-1:0] cnt_q;
  logic [LW:0]   eff;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    eff  = (limit == '0) ? (LW+1)'(1) : {1'b0, limit};
    last = ({1'b0, cnt_q} + (LW+1)'(1)) >= eff;
  end
endmodule

// File: rtl/end_status_seq.sv
module end_status_seq
  import esc_pkg::*;
#(
  parameter int CW    = 4,
  parameter int DW    = 8,
  parameter int SW    = 16,
  parameter int CMDW  = 16,
  parameter int LW    = 8,
  parameter int DELAY = 8,
  parameter logic [CMDW-1:0] CMD_STAT = 16'h0000,
  parameter logic [CMDW-1:0] CMD_RES  = 16'h1000,
  parameter logic [CMDW-1:0] CMD_DRV  = 16'h806C,
  parameter int RF_BIT   = 4,
  parameter int BUSY_BIT = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CW-1:0]   ctrl_status,
  input  logic [LW-1:0]   poll_limit,
  output logic            chip_cmd_wr,
  output logic [CMDW-1:0] chip_cmd_word,
  output logic            chip_rd_stb,
  input  logic [DW-1:0]   chip_rd_data,
  output logic            done,
  output logic [SW-1:0]   end_status,
  output logic            poll_timeout
);
  seq_state_t      state_q;
  logic            go_rd_q, go_wr_q;
  logic [CMDW-1:0] cmd_q;
  logic [SW-1:0]   acc_q, merged;
  logic            rdy;
  logic [DW-1:0]   rdata;
  logic            poll_clr, poll_inc, poll_last;
  fld_sel_t        sel;

  esc_chip_access #(.DW(DW), .CMDW(CMDW), .DELAY(DELAY)) acc_i (
    .clk(clk), .rst(rst), .go_rd(go_rd_q), .go_wr(go_wr_q), .cmd_in(cmd_q),
    .cmd_wr(chip_cmd_wr), .cmd_word(chip_cmd_word), .rd_stb(chip_rd_stb),
    .rd_data(chip_rd_data), .rdy(rdy), .data_out(rdata)
  );

  esc_field_pack #(.DW(DW), .SW(SW)) pack_i (
    .acc(acc_q), .data(rdata), .sel(sel), .merged(merged)
  );

  esc_poll_timer #(.LW(LW)) poll_i (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc),
    .limit(poll_limit), .last(poll_last)
  );

  always_comb begin
    sel = (state_q == ST_RES)  ? FLD_RESULT :
          (state_q == ST_DRES) ? FLD_DRIVE  : FLD_NONE;
    poll_clr = (state_q == ST_DRV) && rdy;
    poll_inc = (state_q == ST_POLL) && rdy && rdata[BUSY_BIT] && !poll_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      go_rd_q      <= 1'b0;
      go_wr_q      <= 1'b0;
      cmd_q        <= '0;
      acc_q        <= '0;
      done         <= 1'b0;
      end_status   <= '0;
      poll_timeout <= 1'b0;
    end else begin
      go_rd_q <= 1'b0;
      go_wr_q <= 1'b0;
      done    <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          acc_q   <= SW'(ctrl_status);
          go_rd_q <= 1'b1;
          cmd_q   <= CMD_STAT;
          state_q <= ST_STAT;
        end
        ST_STAT: if (rdy) begin
          if (rdata[RF_BIT]) begin
            go_rd_q <= 1'b1;
            cmd_q   <= CMD_RES;
            state_q <= ST_RES;
          end else begin
            go_wr_q <= 1'b1;
            cmd_q   <= CMD_DRV;
            state_q <= ST_DRV;
          end
        end
        ST_RES: if (rdy) begin
          acc_q   <= merged;
          go_wr_q <= 1'b1;
          cmd_q   <= CMD_DRV;
          state_q <= ST_DRV;
        end
        ST_DRV: if (rdy) begin
          go_rd_q <= 1'b1;
          cmd_q   <= CMD_STAT;
          state_q <= ST_POLL;
        end
        ST_POLL: if (rdy) begin
          if (!rdata[BUSY_BIT]) begin
            go_rd_q <= 1'b1;
            cmd_q   <= CMD_RES;
            state_q <= ST_DRES;
          end else if (poll_last) begin
            end_status   <= acc_q;
            poll_timeout <= 1'b1;
            done         <= 1'b1;
            state_q      <= ST_IDLE;
          end else begin
            go_rd_q <= 1'b1;
            cmd_q   <= CMD_STAT;
          end
        end
        ST_DRES: if (rdy) begin
          end_status   <= merged;
          poll_timeout <= 1'b0;
          done         <= 1'b1;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/end_status_seq_chk.sv
module end_status_seq_chk #(
  parameter int SW    = 16,
  parameter int CMDW  = 16,
  parameter int DELAY = 8,
  parameter logic [CMDW-1:0] CMD_STAT = 16'h0000,
  parameter logic [CMDW-1:0] CMD_RES  = 16'h1000,
  parameter logic [CMDW-1:0] CMD_DRV  = 16'h806C
) (
  input logic            clk,
  input logic            rst,
  input logic            chip_cmd_wr,
  input logic [CMDW-1:0] chip_cmd_word,
  input logic            chip_rd_stb,
  input logic            done,
  input logic [SW-1:0]   end_status,
  input logic            poll_timeout
);
  localparam int GW = $clog2(DELAY + 2);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                         gap_q <= '0;
    else if (chip_cmd_wr)            gap_q <= GW'(1);
    else if (gap_q != GW'(DELAY+1))  gap_q <= gap_q + 1'b1;
  end

  a_r7_read_spacing: assert property (@(posedge clk) disable iff (rst)
    chip_rd_stb |-> (gap_q == GW'(DELAY)));
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(chip_cmd_wr && chip_rd_stb));
  a_r3_known_cmd: assert property (@(posedge clk) disable iff (rst)
    chip_cmd_wr |-> (chip_cmd_word == CMD_STAT || chip_cmd_word == CMD_RES ||
                     chip_cmd_word == CMD_DRV));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_status_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(end_status));
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(poll_timeout));
  a_r8_timeout_no_drive: assert property (@(posedge clk) disable iff (rst)
    (done && poll_timeout) |-> (end_status[10:4] == 7'd0));
endmodule

bind end_status_seq end_status_seq_chk #(
  .SW(SW), .CMDW(CMDW), .DELAY(DELAY),
  .CMD_STAT(CMD_STAT), .CMD_RES(CMD_RES), .CMD_DRV(CMD_DRV)
) chk_i (
  .clk(clk), .rst(rst), .chip_cmd_wr(chip_cmd_wr),
  .chip_cmd_word(chip_cmd_word), .chip_rd_stb(chip_rd_stb),
  .done(done), .end_status(end_status), .poll_timeout(poll_timeout)
);

// File: tb/end_status_seq_tb_top.sv
module end_status_seq_tb_top;
  localparam int DELAY = 8;
  localparam logic [15:0] C_STAT = 16'h0000;
  localparam logic [15:0] C_RES  = 16'h1000;
  localparam logic [15:0] C_DRV  = 16'h806C;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [3:0]  ctrl_status = '0;
  logic [7:0]  poll_limit = '0;
  logic        chip_cmd_wr, chip_rd_stb, done, poll_timeout;
  logic [15:0] chip_cmd_word, end_status;
  logic [7:0]  chip_rd_data;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  end_status_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .ctrl_status(ctrl_status),
    .poll_limit(poll_limit), .chip_cmd_wr(chip_cmd_wr),
    .chip_cmd_word(chip_cmd_word), .chip_rd_stb(chip_rd_stb),
    .chip_rd_data(chip_rd_data), .done(done), .end_status(end_status),
    .poll_timeout(poll_timeout)
  );

  // chip model
  int          cyc = 0, last_wr = 0, busy_left = 0, busy_cfg = 0;
  int          n_stat = 0, n_res = 0, n_drv = 0, delay_bad = 0;
  logic [15:0] last_cmd = '0, first_cmd = '0;
  bit          drv_issued = 0, got_first = 0, fresh = 0;
  logic [7:0]  st_first = '0, st_noise = '0, res_val = '0, drv_val = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fresh) begin
      drv_issued <= 1'b0;
      got_first  <= 1'b0;
    end
    if (chip_cmd_wr) begin
      last_cmd <= chip_cmd_word;
      last_wr  <= cyc;
      if (!got_first || fresh) first_cmd <= chip_cmd_word;
      got_first <= 1'b1;
      if (chip_cmd_word == C_STAT) n_stat <= n_stat + 1;
      if (chip_cmd_word == C_RES)  n_res  <= n_res + 1;
      if (chip_cmd_word == C_DRV) begin
        n_drv      <= n_drv + 1;
        drv_issued <= 1'b1;
        busy_left  <= busy_cfg;
      end
    end
    if (chip_rd_stb) begin
      if (cyc - last_wr != DELAY) delay_bad <= delay_bad + 1;
      if (last_cmd == C_STAT && drv_issued && busy_left > 0)
        busy_left <= busy_left - 1;
    end
  end

  always_comb begin
    if (last_cmd == C_STAT)
      chip_rd_data = drv_issued ? ((st_noise & 8'h7F) | ((busy_left > 0) ? 8'h80 : 8'h00))
                                : st_first;
    else if (last_cmd == C_RES)
      chip_rd_data = drv_issued ? drv_val : res_val;
    else
      chip_rd_data = 8'h00;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int c, input int rf, input int bn, input int lim, input bit dup);
    int s0, r0, d0, b0, eff, polls, waitc;
    bit tmo;
    logic [15:0] exp;
    @(negedge clk);
    busy_cfg    = bn;
    poll_limit  = 8'(lim);
    ctrl_status = 4'(c);
    res_val  = 8'(c * 37 + bn * 11 + rf * 5);
    drv_val  = 8'(c * 53 + lim * 7 + 1) ^ 8'h80;
    st_first = (8'(c * 29) & 8'hEF) | (rf != 0 ? 8'h10 : 8'h00);
    st_noise = 8'(c * 19 + 3);
    s0 = n_stat; r0 = n_res; d0 = n_drv; b0 = delay_bad;
    start = 1'b1; fresh = 1'b1;
    @(negedge clk);
    start = 1'b0; fresh = 1'b0;
    if (dup) begin
      repeat (3) @(negedge clk);
      ctrl_status = ~4'(c);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 3000) begin
      @(negedge clk);
      waitc++;
    end
    eff = (lim == 0) ? 1 : lim;
    tmo = (bn >= eff);
    polls = tmo ? eff : bn + 1;
    exp = 16'(c) | (rf != 0 ? ((16'(res_val) << 10) & 16'hF000) : 16'h0)
        | (tmo ? 16'h0 : ((16'(drv_val) & 16'h007F) << 4));
    chk(done, "R9", "done seen", done, 1);
    chk(end_status == exp, dup ? "R10" : "R2/R4/R6", "end_status", end_status, exp);
    chk(poll_timeout == tmo, "R8", "poll_timeout", poll_timeout, tmo);
    chk(first_cmd == C_STAT, "R3", "first command", first_cmd, C_STAT);
    chk(n_res - r0 == rf + (tmo ? 0 : 1), "R3", "result reads", n_res - r0, rf + (tmo ? 0 : 1));
    chk(n_drv - d0 == 1, "R5", "drive commands", n_drv - d0, 1);
    chk(n_stat - s0 == 1 + polls, "R6", "status reads", n_stat - s0, 1 + polls);
    chk(delay_bad == b0, "R7", "read delay violations", delay_bad - b0, 0);
    @(negedge clk);
    chk(!done, "R9", "done single cycle", done, 0);
    chk(end_status == exp, "R9", "end_status held", end_status, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && end_status == 0 && poll_timeout == 0 && !chip_cmd_wr && !chip_rd_stb,
        "R1", "outputs in reset", {done, poll_timeout, chip_cmd_wr, chip_rd_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && end_status == 0, "R1", "outputs after reset", end_status, 0);
    // full-field op followed by an empty one: no stale bits (R2)
    run_op(15, 1, 0, 3, 0);
    run_op(0, 0, 5, 2, 0);
    chk(end_status == 16'h0, "R2", "no leak from previous op", end_status, 0);
    for (int c = 0; c < 16; c++)
      for (int rf = 0; rf < 2; rf++)
        for (int bn = 0; bn < 4; bn++)
          for (int li = 0; li < 3; li++)
            run_op(c, rf, bn, (li == 0) ? 0 : li + 1, (c % 5 == 0) && (bn == 1));
    run_op(9, 1, 3, 200, 0);
    run_op(6, 0, 1, 1, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule